// File: doc/BRIEF.md
# Smart Card Pin Direct-Control Unit

This block sits between the automatic sequencer of a smart card interface and the card pins. In normal operation it passes the sequencer's pin requests through to the pins, gated by software clock-enable and data-enable bits, and it ORs in software power and reset-release bits. When the synchronous-mode select input is high, a set of software override values drives the pins directly instead. This lets software handle synchronous cards that do not follow the standard activation and character protocol.

While hardware deactivation is in progress, the deactivation-busy input gives the sequencer sole control of every pin. During that time, writes to the activation control register are dropped. Software reaches three registers through a 16-bit register port: activation control, synchronous transmit override values, and raw receive samples. The receive register returns the card clock and I/O levels after a two-flop synchronizer. The card I/O line is open-drain: the block only ever enables its driver to pull the line low. All pin outputs come from registers, so they change one clock after their cause.

Top module: `sc_pin_ctrl`

## Requirements
- R1: After reset every writable bit is 0 and the pins are VCC off, card reset low, clock low, function code low, I/O driver enabled (pulling low), both buffer enables inactive (high) and clock output enable inactive (high). Address 0 then reads 0x0260 and addresses 1 and 2 read 0x0000.
- R2: Address 0 holds the activation fields: bit 0 power, bit 1 clock enable, bit 2 data enable, bit 3 reset release, bit 4 function code. Address 1 holds the overrides: bit 0 clock level, bit 1 I/O level, bit 2 clock buffer enable, bit 3 data buffer enable, bit 4 reset level, bit 5 function code. Both registers read back what was written.
- R3: The following bits read as zero: bits 15:11 at address 0, bits 15:6 at address 1, bits 15:2 at address 2, and all of address 3. Writes to addresses 2 and 3 change nothing.
- R4: With sync mode low and no deactivation, VCC is power OR the sequencer's VCC request, card reset is reset-release OR the sequencer's reset request, and the function code follows the bit 4 field.
- R5: With sync mode low and no deactivation, the card clock is the sequencer clock AND clock enable. The I/O line is pulled low when the sequencer asks for it or when data enable is 0. The buffer enables follow the sequencer requests.
- R6: With sync mode high and no deactivation, card clock, card reset and function code follow the override bits 0, 4 and 5.
- R7: With sync mode high and no deactivation, the I/O line is pulled low exactly when the I/O override bit is 0. The data and clock buffer enables are the override bits 3 and 2; a 0 makes the active-low enable high.
- R8: The active-low clock output enable is low only when the clock buffer enable is active and VCC is on.
- R9: While deactivation is busy, writes to address 0 are ignored. All pins follow the sequencer requests, with sync mode, software gating and power ignored and the function code held low.
- R10: Address 0 reports the pins in bits 10 to 5: bit 10 card present, bit 9 data buffer enable (active low), bit 8 I/O driver enable (active low), bit 7 card clock, bit 6 clock buffer enable (active low), bit 5 clock output enable (active low).
- R11: Address 2 bit 1 is the synchronized card clock level and bit 0 is the synchronized I/O level. These bits and the card-present bit change two clocks after the pad input changes.
- R12: Every pin output changes on the first rising clock edge after the input or register value that causes it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for read and write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| sync_mode | input | 1 | Selects the software override path |
| deact_busy | input | 1 | Hardware deactivation in progress |
| card_detect | input | 1 | Card presence from the detect switch |
| seq_vcc | input | 1 | Sequencer VCC request |
| seq_rst_n | input | 1 | Sequencer card reset level |
| seq_clk | input | 1 | Sequencer card clock |
| seq_io_low | input | 1 | Sequencer asks to pull I/O low |
| seq_io_buf_en | input | 1 | Sequencer data buffer enable request |
| seq_clk_buf_en | input | 1 | Sequencer clock buffer enable request |
| pad_clk_in | input | 1 | Raw card clock pad level |
| pad_io_in | input | 1 | Raw card I/O pad level |
| card_vcc | output | 1 | Card supply enable |
| card_rst_n | output | 1 | Card reset, low asserts |
| card_clk | output | 1 | Card clock |
| card_fcb | output | 1 | Function code signal |
| card_io_oe_n | output | 1 | Open-drain I/O driver enable, low pulls the line low |
| io_buf_en_n | output | 1 | External data buffer enable, active low |
| clk_buf_en_n | output | 1 | External clock buffer enable, active low |
| clk_oe_n | output | 1 | Clock output enable, active low |

## Verification
If an override or activation register held a wrong value, it would show on a pin one edge after the mode selects that register, and it would be visible right away in the address 0 or 1 readback. A deactivation that fails to take over, or a write that slips through during deactivation, would show as a pin that does not match the sequencer request one edge later, or as a changed field in the address 0 readback. A wrong synchronizer depth shows up as receive or card-present bits that change one clock too early or too late.

// File: rtl/sc_pin_pkg.sv
package sc_pin_pkg;

  localparam int CTL_W = 5;
  localparam int TX_W  = 6;

  localparam int ADDR_CTL = 0;
  localparam int ADDR_TX  = 1;
  localparam int ADDR_RX  = 2;

  localparam int BIT_PRESENT = 10;
  localparam int BIT_IO_BUF  = 9;
  localparam int BIT_IO_OE   = 8;
  localparam int BIT_CLK     = 7;
  localparam int BIT_CLK_BUF = 6;
  localparam int BIT_CLK_OE  = 5;
  localparam int BIT_RX_CLK  = 1;
  localparam int BIT_RX_IO   = 0;

  // activation control word, bit 0 first from the bottom
  typedef struct packed {
    logic fcb;
    logic rst_rel;
    logic data_en;
    logic clk_en;
    logic power;
  } ctl_t;

  // synchronous override word
  typedef struct packed {
    logic ov_fcb;
    logic ov_rst;
    logic ov_data_buf;
    logic ov_clk_buf;
    logic ov_io;
    logic ov_clk;
  } tx_t;

  // sequencer pin requests
  typedef struct packed {
    logic clk_buf_en;
    logic io_buf_en;
    logic io_low;
    logic clk;
    logic rst_n;
    logic vcc;
  } seq_t;

  // registered pin state
  typedef struct packed {
    logic clk_oe_n;
    logic clk_buf_en_n;
    logic io_buf_en_n;
    logic io_oe_n;
    logic fcb;
    logic clk;
    logic rst_n;
    logic vcc;
  } pins_t;

  localparam pins_t PINS_RESET = '{
    clk_oe_n:     1'b1,
    clk_buf_en_n: 1'b1,
    io_buf_en_n:  1'b1,
    io_oe_n:      1'b0,
    fcb:          1'b0,
    clk:          1'b0,
    rst_n:        1'b0,
    vcc:          1'b0
  };

endpackage

// File: rtl/sc_pin_rst_sync.sv
module sc_pin_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/sc_pin_sync.sv
module sc_pin_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] stage_q;
    logic [STAGES-1:0] stage_d;

    always_comb begin
      stage_d = {stage_q[STAGES-2:0], din[b]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q <= '0;
      end else begin
        stage_q <= stage_d;
      end
    end

    assign dout[b] = stage_q[STAGES-1];
  end

endmodule

// File: rtl/sc_pin_regs.sv
module sc_pin_regs
  import sc_pin_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              deact_busy,
  input  pins_t             pins_q,
  input  logic              card_present,
  input  logic              rx_clk,
  input  logic              rx_io,
  output logic [DATA_W-1:0] rdata,
  output ctl_t              ctl_q,
  output tx_t               tx_q
);

  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(ADDR_CTL);
  localparam logic [ADDR_W-1:0] A_TX  = ADDR_W'(ADDR_TX);
  localparam logic [ADDR_W-1:0] A_RX  = ADDR_W'(ADDR_RX);

  ctl_t ctl_d;
  tx_t  tx_d;
  logic ctl_en;
  logic tx_en;
  logic unused_wdata_hi;

  assign unused_wdata_hi = ^wdata[DATA_W-1:TX_W];

  // deactivation blocks the activation register write strobe
  always_comb begin
    ctl_en = wr_en && (addr == A_CTL) && !deact_busy;
    tx_en  = wr_en && (addr == A_TX);
    ctl_d  = ctl_t'(wdata[CTL_W-1:0]);
    tx_d   = tx_t'(wdata[TX_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_en) begin
      ctl_q <= ctl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
    end else if (tx_en) begin
      tx_q <= tx_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_CTL: begin
        rdata[CTL_W-1:0]   = ctl_q;
        rdata[BIT_PRESENT] = card_present;
        rdata[BIT_IO_BUF]  = pins_q.io_buf_en_n;
        rdata[BIT_IO_OE]   = pins_q.io_oe_n;
        rdata[BIT_CLK]     = pins_q.clk;
        rdata[BIT_CLK_BUF] = pins_q.clk_buf_en_n;
        rdata[BIT_CLK_OE]  = pins_q.clk_oe_n;
      end
      A_TX: begin
        rdata[TX_W-1:0] = tx_q;
      end
      A_RX: begin
        rdata[BIT_RX_CLK] = rx_clk;
        rdata[BIT_RX_IO]  = rx_io;
      end
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/sc_pin_drive.sv
module sc_pin_drive
  import sc_pin_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sync_mode,
  input  logic  deact_busy,
  input  seq_t  seq,
  input  ctl_t  ctl,
  input  tx_t   tx,
  output pins_t pins_q
);

  pins_t pins_d;
  logic  vcc_d;
  logic  rst_n_d;
  logic  clk_d;
  logic  fcb_d;
  logic  io_low_d;
  logic  io_buf_d;
  logic  clk_buf_d;

  // source selection: deactivation over sync override over sequencer
  always_comb begin
    if (deact_busy) begin
      vcc_d     = seq.vcc;
      rst_n_d   = seq.rst_n;
      clk_d     = seq.clk;
      fcb_d     = 1'b0;
      io_low_d  = seq.io_low;
      io_buf_d  = seq.io_buf_en;
      clk_buf_d = seq.clk_buf_en;
    end else if (sync_mode) begin
      vcc_d     = ctl.power | seq.vcc;
      rst_n_d   = tx.ov_rst;
      clk_d     = tx.ov_clk;
      fcb_d     = tx.ov_fcb;
      io_low_d  = ~tx.ov_io;
      io_buf_d  = tx.ov_data_buf;
      clk_buf_d = tx.ov_clk_buf;
    end else begin
      vcc_d     = ctl.power | seq.vcc;
      rst_n_d   = ctl.rst_rel | seq.rst_n;
      clk_d     = seq.clk & ctl.clk_en;
      fcb_d     = ctl.fcb;
      io_low_d  = seq.io_low | ~ctl.data_en;
      io_buf_d  = seq.io_buf_en;
      clk_buf_d = seq.clk_buf_en;
    end
  end

  always_comb begin
    pins_d.vcc          = vcc_d;
    pins_d.rst_n        = rst_n_d;
    pins_d.clk          = clk_d;
    pins_d.fcb          = fcb_d;
    pins_d.io_oe_n      = ~io_low_d;
    pins_d.io_buf_en_n  = ~io_buf_d;
    pins_d.clk_buf_en_n = ~clk_buf_d;
    pins_d.clk_oe_n     = ~(clk_buf_d & vcc_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q <= PINS_RESET;
    end else begin
      pins_q <= pins_d;
    end
  end

endmodule

// File: rtl/sc_pin_ctrl.sv
module sc_pin_ctrl
  import sc_pin_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              sync_mode,
  input  logic              deact_busy,
  input  logic              card_detect,
  input  logic              seq_vcc,
  input  logic              seq_rst_n,
  input  logic              seq_clk,
  input  logic              seq_io_low,
  input  logic              seq_io_buf_en,
  input  logic              seq_clk_buf_en,
  input  logic              pad_clk_in,
  input  logic              pad_io_in,
  output logic              card_vcc,
  output logic              card_rst_n,
  output logic              card_clk,
  output logic              card_fcb,
  output logic              card_io_oe_n,
  output logic              io_buf_en_n,
  output logic              clk_buf_en_n,
  output logic              clk_oe_n
);

  localparam int RAW_W = 3;

  logic             rst_sync_n;
  logic [RAW_W-1:0] raw_in;
  logic [RAW_W-1:0] raw_sync;
  ctl_t             ctl_word;
  tx_t              tx_word;
  seq_t             seq_req;
  pins_t            pins_q;

  sc_pin_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign raw_in = {card_detect, pad_clk_in, pad_io_in};

  sc_pin_sync #(.WIDTH(RAW_W), .STAGES(SYNC_STAGES)) u_raw_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .din   (raw_in),
    .dout  (raw_sync)
  );

  sc_pin_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .wr_en        (reg_wr),
    .addr         (reg_addr),
    .wdata        (reg_wdata),
    .deact_busy   (deact_busy),
    .pins_q       (pins_q),
    .card_present (raw_sync[2]),
    .rx_clk       (raw_sync[1]),
    .rx_io        (raw_sync[0]),
    .rdata        (reg_rdata),
    .ctl_q        (ctl_word),
    .tx_q         (tx_word)
  );

  always_comb begin
    seq_req.vcc        = seq_vcc;
    seq_req.rst_n      = seq_rst_n;
    seq_req.clk        = seq_clk;
    seq_req.io_low     = seq_io_low;
    seq_req.io_buf_en  = seq_io_buf_en;
    seq_req.clk_buf_en = seq_clk_buf_en;
  end

  sc_pin_drive u_drive (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .sync_mode  (sync_mode),
    .deact_busy (deact_busy),
    .seq        (seq_req),
    .ctl        (ctl_word),
    .tx         (tx_word),
    .pins_q     (pins_q)
  );

  assign card_vcc     = pins_q.vcc;
  assign card_rst_n   = pins_q.rst_n;
  assign card_clk     = pins_q.clk;
  assign card_fcb     = pins_q.fcb;
  assign card_io_oe_n = pins_q.io_oe_n;
  assign io_buf_en_n  = pins_q.io_buf_en_n;
  assign clk_buf_en_n = pins_q.clk_buf_en_n;
  assign clk_oe_n     = pins_q.clk_oe_n;

endmodule

// File: rtl/sc_pin_ctrl_chk.sv
module sc_pin_ctrl_chk
  import sc_pin_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sync_mode,
  input logic              deact_busy,
  input logic              seq_vcc,
  input logic              seq_rst_n,
  input ctl_t              ctl_q,
  input tx_t               tx_q,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              card_vcc,
  input logic              card_rst_n,
  input logic              card_clk,
  input logic              card_io_oe_n
);

  p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:BIT_PRESENT+1] == '0);

  p_ctl_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    deact_busy |=> $stable(ctl_q));

  p_deact_vcc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    deact_busy |=> card_vcc == $past(seq_vcc));

  p_sync_clk_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && !deact_busy) |=> card_clk == $past(tx_q.ov_clk));

  p_sync_io_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && !deact_busy) |=> card_io_oe_n == $past(tx_q.ov_io));

  p_norm_rst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_mode && !deact_busy) |=>
      card_rst_n == ($past(ctl_q.rst_rel) | $past(seq_rst_n)));

endmodule

bind sc_pin_ctrl sc_pin_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .sync_mode    (sync_mode),
  .deact_busy   (deact_busy),
  .seq_vcc      (seq_vcc),
  .seq_rst_n    (seq_rst_n),
  .ctl_q        (ctl_word),
  .tx_q         (tx_word),
  .reg_rdata    (reg_rdata),
  .card_vcc     (card_vcc),
  .card_rst_n   (card_rst_n),
  .card_clk     (card_clk),
  .card_io_oe_n (card_io_oe_n)
);

// File: tb/sc_pin_ctrl_bench.sv
`timescale 1ns/1ps
module sc_pin_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        sync_mode = 1'b0;
  logic        deact_busy = 1'b0;
  logic        card_detect = 1'b0;
  logic [5:0]  seq = 6'h0;
  logic        pad_clk_in = 1'b0;
  logic        pad_io_in = 1'b0;
  logic        card_vcc, card_rst_n, card_clk, card_fcb;
  logic        card_io_oe_n, io_buf_en_n, clk_buf_en_n, clk_oe_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sc_pin_ctrl u_sc_pin_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sync_mode(sync_mode),
    .deact_busy(deact_busy), .card_detect(card_detect),
    .seq_vcc(seq[0]), .seq_rst_n(seq[1]), .seq_clk(seq[2]),
    .seq_io_low(seq[3]), .seq_io_buf_en(seq[4]), .seq_clk_buf_en(seq[5]),
    .pad_clk_in(pad_clk_in), .pad_io_in(pad_io_in),
    .card_vcc(card_vcc), .card_rst_n(card_rst_n), .card_clk(card_clk),
    .card_fcb(card_fcb), .card_io_oe_n(card_io_oe_n),
    .io_buf_en_n(io_buf_en_n), .clk_buf_en_n(clk_buf_en_n), .clk_oe_n(clk_oe_n)
  );

  // {sync, deact, seq[5:0], ctl[4:0], tx[5:0], expected pins[7:0]}
  // pins: 7 clk_oe_n, 6 clk_buf_en_n, 5 io_buf_en_n, 4 io_oe_n, 3 fcb, 2 clk, 1 rst_n, 0 vcc
  localparam int NV = 8;
  localparam logic [26:0] VEC [NV] = '{
    {1'b0, 1'b0, 6'h00, 5'h00, 6'h00, 8'hE0},
    {1'b0, 1'b0, 6'h37, 5'h16, 6'h00, 8'h1F},
    {1'b0, 1'b0, 6'h37, 5'h09, 6'h00, 8'h03},
    {1'b0, 1'b0, 6'h0C, 5'h06, 6'h00, 8'hE4},
    {1'b1, 1'b0, 6'h00, 5'h01, 6'h1F, 8'h17},
    {1'b1, 1'b0, 6'h3F, 5'h00, 6'h28, 8'hC9},
    {1'b1, 1'b1, 6'h14, 5'h1F, 6'h3F, 8'hD4},
    {1'b0, 1'b1, 6'h2B, 5'h1F, 6'h00, 8'h23}
  };

  function automatic logic [7:0] pins_now();
    return {clk_oe_n, clk_buf_en_n, io_buf_en_n, card_io_oe_n,
            card_fcb, card_clk, card_rst_n, card_vcc};
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 pins after reset", {8'h0, pins_now()}, 16'h00E0);
    reg_read(2'd0, rd); check("R1 addr0 after reset", rd, 16'h0260);
    reg_read(2'd1, rd); check("R1 addr1 after reset", rd, 16'h0000);
    reg_read(2'd2, rd); check("R1 addr2 after reset", rd, 16'h0000);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [7:0] exp;
      string ta, tb;
      exp = VEC[i][7:0];
      @(negedge clk);
      deact_busy = 1'b0;
      reg_write(2'd0, {11'h0, VEC[i][18:14]});
      reg_write(2'd1, {10'h0, VEC[i][13:8]});
      reg_read(2'd0, rd); check("R2 ctl readback", {11'h0, rd[4:0]}, {11'h0, VEC[i][18:14]});
      reg_read(2'd1, rd); check("R2 tx readback", rd, {10'h0, VEC[i][13:8]});
      sync_mode  = VEC[i][26];
      deact_busy = VEC[i][25];
      seq        = VEC[i][24:19];
      @(negedge clk);
      ta = VEC[i][25] ? "R9 core pins" : (VEC[i][26] ? "R6 core pins" : "R4 core pins");
      tb = VEC[i][25] ? "R9 io/buffers" : (VEC[i][26] ? "R7 io/buffers" : "R5 io/buffers");
      check(ta, {8'h0, pins_now() & 8'h0F}, {8'h0, exp & 8'h0F});
      check(tb, {8'h0, pins_now() & 8'h70}, {8'h0, exp & 8'h70});
      check("R8 clk_oe_n", {15'h0, clk_oe_n}, {15'h0, exp[7]});
      reg_read(2'd0, rd);
      check("R10 status bits", {11'h0, rd[9:5]}, {11'h0, exp[5], exp[4], exp[2], exp[6], exp[7]});
    end

    // R12 latency
    @(negedge clk);
    deact_busy = 1'b0; sync_mode = 1'b0; seq = 6'h00;
    reg_write(2'd0, 16'h0006);
    @(negedge clk);
    seq[2] = 1'b1;
    #1;
    check("R12 no change before edge", {15'h0, card_clk}, 16'h0000);
    @(negedge clk);
    check("R12 change after one edge", {15'h0, card_clk}, 16'h0001);

    // R11 synchronizer latency
    pad_clk_in = 1'b1; pad_io_in = 1'b0; card_detect = 1'b1;
    @(negedge clk);
    reg_read(2'd2, rd); check("R11 rx after one edge", rd, 16'h0000);
    @(negedge clk);
    reg_read(2'd2, rd); check("R11 rx after two edges", rd, 16'h0002);
    reg_read(2'd0, rd); check("R11 card present", {15'h0, rd[10]}, 16'h0001);

    // R3 reserved and read-only
    reg_write(2'd3, 16'hFFFF);
    reg_read(2'd3, rd); check("R3 addr3 reads zero", rd, 16'h0000);
    reg_write(2'd2, 16'hFFFF);
    reg_read(2'd2, rd); check("R3 addr2 write ignored", rd, 16'h0002);
    reg_write(2'd1, 16'hFFFF);
    reg_read(2'd1, rd); check("R3 addr1 upper zero", rd, 16'h003F);
    reg_write(2'd0, 16'hFFFF);
    reg_read(2'd0, rd); check("R3 addr0 upper zero", rd & 16'hF81F, 16'h001F);

    // R9 write blocked during deactivation
    @(negedge clk);
    deact_busy = 1'b1;
    reg_write(2'd0, 16'h0000);
    reg_read(2'd0, rd); check("R9 write ignored in deactivation", {11'h0, rd[4:0]}, 16'h001F);
    @(negedge clk);
    deact_busy = 1'b0;
    reg_write(2'd0, 16'h0000);
    reg_read(2'd0, rd); check("R9 write accepted after deactivation", {11'h0, rd[4:0]}, 16'h0000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule